// File: doc/BRIEF.md
# Bus-Injection Boot Copier

The block boots a small 8-bit system whose memory holds nothing but RAM after start-up. It owns the CPU clock (as a one-cycle clock-enable pulse) and the CPU reset. It never drives an address line. Instead, it places instruction bytes on the CPU data bus cycle by cycle, so the CPU itself runs a tiny copy program. Each copied byte is loaded from ROM and stored to the same address in RAM. The controller enables ROM only on the load's data cycle and RAM only on the store's data cycle.

Each copied byte takes a thirteen-cycle step. The step starts with an absolute jump to a fixed park address, which keeps the program counter out of the I/O window. Then comes an absolute load from the copy address, whose data the controller captures from the bus. Then an immediate load of that captured byte, and finally an absolute store to the same address. The copy address begins at zero and climbs. It hops over a fixed I/O window and stops when it wraps to zero. After that the controller resets the CPU again, switches the CPU clock to a selectable run rate, stops driving the bus, hands the memory map to RAM and releases reset.

The copy runs at a fixed slow CPU rate of one CPU cycle per `COPY_DIV` system clocks. The run rate is `COPY_DIV >> rate_sel`, so an 8 MHz system clock gives 1 MHz during the copy and 1, 2, 4 or 8 MHz afterwards.

Top module: `boot_loader_ctl`

## Requirements
- R1: While and right after `rst` is high, `done_o`, `rom_en_o`, `ram_en_o` and `inj_oe_o` are 0 and `cpu_rst_o` is 1.
- R2: Before run mode, `cpu_ce_o` pulses exactly once every `COPY_DIV` clocks, whatever the value of `rate_sel`.
- R3: Each copy step injects, in order, 4C, park-low, park-high, AD, addr-low, addr-high, then after the data cycle A9, captured byte, 8D, addr-low, addr-high. As a result every opcode or operand fetch of the CPU lies within 16 bytes above `PARK_ADDR`.
- R4: `rom_en_o` is high only during the CPU read cycle of the absolute load, and that read targets the current copy address.
- R5: `ram_en_o` is high during each store's write cycle, and the value written equals the ROM byte at the same address.
- R6: The copy addresses run upward from 0 in steps of one.
- R7: Addresses from `SKIP_BASE` to `SKIP_BASE+SKIP_LEN-1` are never read or written during the copy, and the copy address never holds them.
- R8: The copy ends when the address wraps past the top of the `ADDR_W`-bit space, after exactly 2^ADDR_W − SKIP_LEN stores.
- R9: Before the copy starts, reset is held for `RST_HOLD` CPU cycles. After release, the CPU runs five dummy cycles and then fetches the reset vector over two cycles (low byte, then high byte), which the controller supplies as `PARK_ADDR`.
- R10: Once `done_o` is high, `cpu_rst_o` and `inj_oe_o` and `rom_en_o` are 0 and `ram_en_o` is 1.
- R11: In run mode, `cpu_ce_o` pulses every `COPY_DIV >> rate_sel` clocks, and a change of `rate_sel` takes effect at once.
- R12: `rom_en_o` and `ram_en_o` are never high together, and the injection driver is off whenever ROM is enabled.
- R13: `done_o` stays high until the next `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a new boot |
| rate_sel | input | 2 | Run clock select: divider `COPY_DIV >> rate_sel` |
| bus_data_i | input | 8 | Value on the CPU data bus, sampled on the load data cycle |
| cpu_ce_o | output | 1 | One-clock pulse marking the end of each CPU cycle |
| cpu_rst_o | output | 1 | CPU reset, active high |
| inj_data_o | output | 8 | Byte driven onto the CPU data bus |
| inj_oe_o | output | 1 | Enable for the injection driver (0 = high impedance) |
| rom_en_o | output | 1 | ROM output enable |
| ram_en_o | output | 1 | RAM enable |
| done_o | output | 1 | Run mode entered |

## Verification
Two things can meet in the last cycle of the final step: the store of the last byte and the wrap of the address into the finish sequence. The bench lets the copy reach the top address, then checks that this last store still lands, that the store count matches, and that the run-mode outputs appear right afterwards. The bench also watches every load data cycle and every write cycle against its own list of expected addresses, so a step that is late or early in either direction would show up. A reset in the middle of a copy checks that a restart begins cleanly.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_SYNC = 3'd0,
    ST_BOOT = 3'd1,
    ST_COPY = 3'd2,
    ST_FIN  = 3'd3,
    ST_RUN  = 3'd4
  } boot_st_e;

  localparam logic [7:0] OP_JMP_ABS = 8'h4C;
  localparam logic [7:0] OP_LDA_ABS = 8'hAD;
  localparam logic [7:0] OP_LDA_IMM = 8'hA9;
  localparam logic [7:0] OP_STA_ABS = 8'h8D;

  // step cycle indices within one copied byte
  localparam int unsigned STEP_LOAD_DATA  = 6;
  localparam int unsigned STEP_STORE_DATA = 12;
  localparam int unsigned STEP_LAST       = 12;
  // CPU reset sequence: dummy cycles, then vector low, vector high
  localparam int unsigned BOOT_VEC_LO     = 5;
  localparam int unsigned BOOT_LAST       = 6;
endpackage

// File: rtl/boot_tick_gen.sv
module boot_tick_gen #(
  parameter int unsigned COPY_DIV = 8,
  localparam int unsigned CW = $clog2(COPY_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_mode,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div;

  always_comb begin
    if (run_mode) div = CW'(COPY_DIV >> rate_sel);
    else          div = CW'(COPY_DIV);
    if (div == '0) div = CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div - CW'(1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_copy_addr.sv
module boot_copy_addr #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SKIP_BASE = 16'hC000,
  parameter int unsigned SKIP_LEN  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] SKIP_FROM = ADDR_W'(SKIP_BASE);
  localparam logic [ADDR_W-1:0] SKIP_TO   = ADDR_W'(SKIP_BASE + SKIP_LEN);

  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = addr + ADDR_W'(1);
    if (SKIP_LEN != 0 && nxt == SKIP_FROM) nxt = SKIP_TO;
    last = (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)      addr <= '0;
    else if (adv) addr <= nxt;
  end
endmodule

// File: rtl/boot_step_decode.sv
module boot_step_decode
  import boot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PARK_ADDR = 16'h1000
) (
  input  boot_st_e          state,
  input  logic [2:0]        boot_cnt,
  input  logic [3:0]        step_idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cap_data,
  output logic [7:0]        inj_byte,
  output logic              inj_oe,
  output logic              rom_en,
  output logic              ram_en,
  output logic              cpu_rst,
  output logic              done
);
  logic [15:0] a16;
  logic [15:0] p16;

  assign a16 = 16'(addr);
  assign p16 = 16'(PARK_ADDR);

  always_comb begin
    inj_byte = 8'h00;
    inj_oe   = 1'b0;
    rom_en   = 1'b0;
    ram_en   = 1'b0;
    cpu_rst  = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_SYNC: cpu_rst = 1'b1;
      ST_BOOT: begin
        if (boot_cnt == 3'(BOOT_VEC_LO)) begin
          inj_byte = p16[7:0];
          inj_oe   = 1'b1;
        end else if (boot_cnt == 3'(BOOT_LAST)) begin
          inj_byte = p16[15:8];
          inj_oe   = 1'b1;
        end
      end
      ST_COPY: begin
        inj_oe = 1'b1;
        unique case (step_idx)
          4'd0:  inj_byte = OP_JMP_ABS;
          4'd1:  inj_byte = p16[7:0];
          4'd2:  inj_byte = p16[15:8];
          4'd3:  inj_byte = OP_LDA_ABS;
          4'd4:  inj_byte = a16[7:0];
          4'd5:  inj_byte = a16[15:8];
          4'd6:  begin inj_oe = 1'b0; rom_en = 1'b1; end
          4'd7:  inj_byte = OP_LDA_IMM;
          4'd8:  inj_byte = cap_data;
          4'd9:  inj_byte = OP_STA_ABS;
          4'd10: inj_byte = a16[7:0];
          4'd11: inj_byte = a16[15:8];
          4'd12: begin inj_oe = 1'b0; ram_en = 1'b1; end
          default: inj_oe = 1'b0;
        endcase
      end
      ST_FIN: begin
        cpu_rst = 1'b1;
        ram_en  = 1'b1;
      end
      ST_RUN: begin
        ram_en = 1'b1;
        done   = 1'b1;
      end
      default: cpu_rst = 1'b1;
    endcase
  end
endmodule

// File: rtl/boot_loader_ctl.sv
module boot_loader_ctl
  import boot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned COPY_DIV  = 8,
  parameter int unsigned SKIP_BASE = 16'hC000,
  parameter int unsigned SKIP_LEN  = 256,
  parameter int unsigned PARK_ADDR = 16'h1000,
  parameter int unsigned RST_HOLD  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic [7:0] bus_data_i,
  output logic       cpu_ce_o,
  output logic       cpu_rst_o,
  output logic [7:0] inj_data_o,
  output logic       inj_oe_o,
  output logic       rom_en_o,
  output logic       ram_en_o,
  output logic       done_o
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);

  boot_st_e          state_q;
  logic [2:0]        boot_cnt_q;
  logic [HW-1:0]     hold_q;
  logic [3:0]        step_q;
  logic [7:0]        cap_q;
  logic [ADDR_W-1:0] copy_addr;
  logic              addr_last;
  logic              tick;
  logic              run_mode;
  logic              addr_adv;
  logic              in_copy;

  logic [7:0] d_byte;
  logic       d_oe, d_rom, d_ram, d_rst, d_done;

  assign run_mode = (state_q == ST_FIN) || (state_q == ST_RUN);
  assign in_copy  = (state_q == ST_COPY);
  assign addr_adv = tick && in_copy && (step_q == 4'(STEP_LAST)) && !addr_last;

  boot_tick_gen #(.COPY_DIV(COPY_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_mode(run_mode), .rate_sel(rate_sel), .tick(tick)
  );

  boot_copy_addr #(.ADDR_W(ADDR_W), .SKIP_BASE(SKIP_BASE), .SKIP_LEN(SKIP_LEN)) u_addr (
    .clk(clk), .rst(rst), .adv(addr_adv), .addr(copy_addr), .last(addr_last)
  );

  boot_step_decode #(.ADDR_W(ADDR_W), .PARK_ADDR(PARK_ADDR)) u_dec (
    .state(state_q), .boot_cnt(boot_cnt_q), .step_idx(step_q), .addr(copy_addr),
    .cap_data(cap_q), .inj_byte(d_byte), .inj_oe(d_oe), .rom_en(d_rom),
    .ram_en(d_ram), .cpu_rst(d_rst), .done(d_done)
  );

  // sequencing: everything advances on CPU cycle boundaries
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SYNC;
      boot_cnt_q <= '0;
      hold_q     <= '0;
      step_q     <= '0;
      cap_q      <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_SYNC: begin
          if (hold_q == HW'(RST_HOLD - 1)) begin
            hold_q     <= '0;
            boot_cnt_q <= '0;
            state_q    <= ST_BOOT;
          end else begin
            hold_q <= hold_q + HW'(1);
          end
        end
        ST_BOOT: begin
          if (boot_cnt_q == 3'(BOOT_LAST)) begin
            step_q  <= '0;
            state_q <= ST_COPY;
          end else begin
            boot_cnt_q <= boot_cnt_q + 3'd1;
          end
        end
        ST_COPY: begin
          if (step_q == 4'(STEP_LOAD_DATA)) cap_q <= bus_data_i;
          if (step_q == 4'(STEP_LAST)) begin
            step_q <= '0;
            if (addr_last) begin
              hold_q  <= '0;
              state_q <= ST_FIN;
            end
          end else begin
            step_q <= step_q + 4'd1;
          end
        end
        ST_FIN: begin
          if (hold_q == HW'(RST_HOLD - 1)) state_q <= ST_RUN;
          else                             hold_q  <= hold_q + HW'(1);
        end
        ST_RUN: state_q <= ST_RUN;
        default: state_q <= ST_SYNC;
      endcase
    end
  end

  // registered pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rst_o  <= 1'b1;
      inj_data_o <= 8'h00;
      inj_oe_o   <= 1'b0;
      rom_en_o   <= 1'b0;
      ram_en_o   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      cpu_rst_o  <= d_rst;
      inj_data_o <= d_byte;
      inj_oe_o   <= d_oe;
      rom_en_o   <= d_rom;
      ram_en_o   <= d_ram;
      done_o     <= d_done;
    end
  end

  assign cpu_ce_o = tick;
endmodule

// File: rtl/boot_loader_ctl_chk.sv
module boot_loader_ctl_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SKIP_BASE = 16'hC000,
  parameter int unsigned SKIP_LEN  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ce_o,
  input logic              cpu_rst_o,
  input logic              inj_oe_o,
  input logic              rom_en_o,
  input logic              ram_en_o,
  input logic              done_o,
  input logic              in_copy,
  input logic [ADDR_W-1:0] copy_addr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done_o && !rom_en_o && !ram_en_o && !inj_oe_o && cpu_rst_o));

  assert_copy_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (in_copy && cpu_ce_o) |=> !cpu_ce_o);

  assert_skip_window_R7: assert property (@(posedge clk) disable iff (rst)
    !((32'(copy_addr) >= SKIP_BASE) && (32'(copy_addr) < SKIP_BASE + SKIP_LEN)));

  assert_run_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ram_en_o && !rom_en_o && !inj_oe_o && !cpu_rst_o));

  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(rom_en_o && ram_en_o));

  assert_rom_no_drive_R12: assert property (@(posedge clk) disable iff (rst)
    rom_en_o |-> !inj_oe_o);

  assert_done_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
endmodule

bind boot_loader_ctl boot_loader_ctl_chk #(
  .ADDR_W(ADDR_W), .SKIP_BASE(SKIP_BASE), .SKIP_LEN(SKIP_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cpu_ce_o(cpu_ce_o), .cpu_rst_o(cpu_rst_o),
  .inj_oe_o(inj_oe_o), .rom_en_o(rom_en_o), .ram_en_o(ram_en_o),
  .done_o(done_o), .in_copy(in_copy), .copy_addr(copy_addr)
);

// File: tb/boot_loader_ctl_test.sv
module boot_loader_ctl_test;
  localparam int AW    = 9;
  localparam int MSZ   = 1 << AW;
  localparam int DIV   = 8;
  localparam int SBASE = 'h100;
  localparam int SLEN  = 64;
  localparam int PARK  = 'h1C8;
  localparam int NCOPY = MSZ - SLEN;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'd3;
  logic [7:0] bus;
  logic       cpu_ce, cpu_rst, inj_oe, rom_en, ram_en, done;
  logic [7:0] inj_data;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  boot_loader_ctl #(
    .ADDR_W(AW), .COPY_DIV(DIV), .SKIP_BASE(SBASE), .SKIP_LEN(SLEN),
    .PARK_ADDR(PARK), .RST_HOLD(2)
  ) uut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .bus_data_i(bus),
    .cpu_ce_o(cpu_ce), .cpu_rst_o(cpu_rst), .inj_data_o(inj_data),
    .inj_oe_o(inj_oe), .rom_en_o(rom_en), .ram_en_o(ram_en), .done_o(done)
  );

  // memories and a small CPU model (subset of an 8-bit accumulator CPU)
  logic [7:0]    rom [MSZ];
  logic [7:0]    ram [MSZ];
  logic [2:0]    rcnt;
  logic          running;
  logic [AW-1:0] pc;
  logic [7:0]    op, lo, hi, acc;
  logic [1:0]    cyc;
  logic [AW-1:0] m_addr;
  logic          m_rw;
  int            boot_pc;
  int            bad_op;

  assign m_addr = (running && cyc == 2'd3) ? AW'({hi, lo}) : pc;
  assign m_rw   = !(running && cyc == 2'd3 && op == 8'h8D);
  assign bus    = rom_en ? rom[m_addr] : (inj_oe ? inj_data : 8'h00);

  always @(posedge clk) begin
    if (rst || (cpu_ce && cpu_rst)) begin
      rcnt <= 3'd0; running <= 1'b0; cyc <= 2'd0; pc <= '0;
    end else if (cpu_ce && !done) begin
      if (!running) begin
        if (rcnt == 3'd5) lo <= bus;
        if (rcnt == 3'd6) begin
          pc <= AW'({bus, lo}); running <= 1'b1; boot_pc <= int'({bus, lo});
        end
        rcnt <= rcnt + 3'd1;
      end else begin
        case (cyc)
          2'd0: begin op <= bus; pc <= pc + 1'b1; cyc <= 2'd1; end
          2'd1: begin
            if (op == 8'hA9) begin acc <= bus; pc <= pc + 1'b1; cyc <= 2'd0; end
            else if (op == 8'h4C || op == 8'hAD || op == 8'h8D) begin
              lo <= bus; pc <= pc + 1'b1; cyc <= 2'd2;
            end else begin bad_op <= bad_op + 1; cyc <= 2'd0; end
          end
          2'd2: begin
            if (op == 8'h4C) begin pc <= AW'({bus, lo}); cyc <= 2'd0; end
            else begin hi <= bus; pc <= pc + 1'b1; cyc <= 2'd3; end
          end
          default: begin
            if (op == 8'hAD) acc <= bus;
            else if (ram_en) ram[m_addr] <= acc;
            cyc <= 2'd0;
          end
        endcase
      end
    end
  end

  // bus monitor, sampled mid-cycle
  int exp_addr, n_wr, n_rd, bad_rd, bad_wr, bad_fetch, bad_skip;
  bit mon_on;

  function automatic int next_addr(input int a);
    int n;
    n = (a + 1) % MSZ;
    if (n == SBASE) n = SBASE + SLEN;
    return n;
  endfunction

  always @(negedge clk) begin
    if (mon_on && !rst && cpu_ce && !cpu_rst && running && !done) begin
      if (int'(m_addr) >= SBASE && int'(m_addr) < SBASE + SLEN && (rom_en || !m_rw))
        bad_skip++;
      if (rom_en) begin
        n_rd++;
        if (!m_rw || int'(m_addr) != exp_addr) bad_rd++;
      end
      if (!m_rw) begin
        if (!ram_en || int'(m_addr) != exp_addr || acc != rom[exp_addr]) bad_wr++;
        n_wr++;
        exp_addr = next_addr(exp_addr);
      end
      if (!rom_en && m_rw && (int'(m_addr) - PARK < 0 || int'(m_addr) - PARK >= 16))
        bad_fetch++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < MSZ; i++) ram[i] = 8'hEE;
    exp_addr = 0; n_wr = 0; n_rd = 0; bad_rd = 0; bad_wr = 0;
    bad_fetch = 0; bad_skip = 0; bad_op = 0; boot_pc = -1;
  endtask

  // clocks between two cpu_ce pulses
  task automatic measure_gap(output int gap);
    gap = 0;
    do @(negedge clk); while (!cpu_ce);
    do begin @(negedge clk); gap++; end while (!cpu_ce);
  endtask

  task automatic test_reset_state();
    apply_reset();
    chk(done == 0 && rom_en == 0 && ram_en == 0 && inj_oe == 0, "R1 outputs idle",
        {done, rom_en, ram_en, inj_oe}, 0);
    chk(cpu_rst == 1, "R1 cpu reset held", cpu_rst, 1);
  endtask

  task automatic test_mid_reset();
    int g;
    rst = 1'b0; mon_on = 1'b1;
    repeat (3000) @(posedge clk);
    measure_gap(g);
    chk(g == DIV, "R2 copy rate ignores rate_sel", g, DIV);
    apply_reset();
    chk(done == 0 && cpu_rst == 1 && rom_en == 0, "R1 restart mid-copy",
        {done, cpu_rst, rom_en}, 2);
  endtask

  task automatic test_full_copy();
    int g, bad_mem, bad_hole;
    rate_sel = 2'd0;
    rst = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    chk(cpu_rst == 1, "R9 reset pulse at copy start", cpu_rst, 1);
    wait (done === 1'b1);
    @(negedge clk);
    mon_on = 1'b0;
    chk(boot_pc == PARK, "R9 reset vector is park address", boot_pc, PARK);
    chk(bad_op == 0, "R3 only expected opcodes injected", bad_op, 0);
    chk(bad_fetch == 0, "R3 fetches stay near park", bad_fetch, 0);
    chk(bad_rd == 0 && n_rd == NCOPY, "R4 ROM reads on load data cycle", n_rd, NCOPY);
    chk(bad_wr == 0, "R5 stores with RAM enabled carry ROM byte", bad_wr, 0);
    chk(exp_addr == 0, "R6 ascending addresses wrapped to zero", exp_addr, 0);
    chk(bad_skip == 0, "R7 no access to skip window", bad_skip, 0);
    chk(n_wr == NCOPY, "R8 store count", n_wr, NCOPY);
    bad_mem = 0; bad_hole = 0;
    for (int i = 0; i < MSZ; i++) begin
      if (i >= SBASE && i < SBASE + SLEN) begin
        if (ram[i] != 8'hEE) bad_hole++;
      end else if (ram[i] != rom[i]) bad_mem++;
    end
    chk(bad_mem == 0, "R5 RAM image equals ROM", bad_mem, 0);
    chk(bad_hole == 0, "R7 skip window untouched", bad_hole, 0);
    chk(cpu_rst == 0 && ram_en == 1 && rom_en == 0 && inj_oe == 0,
        "R10 run-mode pins", {cpu_rst, ram_en, rom_en, inj_oe}, 4);
    for (int s = 0; s < 4; s++) begin
      rate_sel = 2'(s);
      repeat (20) @(negedge clk);
      measure_gap(g);
      chk(g == (DIV >> s), "R11 run clock divider", g, DIV >> s);
    end
    chk(done == 1, "R13 done stays high", done, 1);
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) rom[i] = 8'((i * 37 + 11) ^ (i >> 4));
    mon_on = 1'b0;
    test_reset_state();
    test_mid_reset();
    test_full_copy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule